// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block keeps a small bank of control registers closed to writes until software proves intent by writing a fixed three-byte key, one byte per write, to a single key register. The key has to arrive in exact order: 0x59, then 0x16, then 0x88. Only after the last byte does the block open, and a read-only status bit then reports 1.

While the block is locked, writes to the protected registers are dropped without any error. Once the block is open, every write to a protected register goes through, and the block drives a write-enable qualifier for it. Any later write to the key register closes the block again.

The bus is a plain single-cycle register port. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `prot_unlock_seq`

## Requirements
- R1: After reset the block is locked, the status bit reads 0 and every protected register reads 0.
- R2: Writing 0x59, 0x16 and 0x88 in that order to bits 7:0 at the key address (word address 0) sets the status bit to 1. The new value is visible from the clock edge that accepts the third byte, and not before.
- R3: A read of the key address returns the status in bit 0 (1 = unlocked) and zero in every other bit, so the written key is never read back.
- R4: While locked, a write to a protected register (word addresses 1 to 3) leaves its content unchanged, and `prot_wr_en` stays low.
- R5: While unlocked, a write to a protected register stores the write data, and `prot_wr_en` is high in that cycle.
- R6: A key byte that is not the expected next byte restarts detection. If that mismatching byte is 0x59, it counts as the first byte of a new sequence.
- R7: Any write to the key address while unlocked relocks the block, and the status reads 0 from the next cycle.
- R8: Writes to addresses other than the key address, made between key bytes, do not break a sequence in progress.
- R9: A read of an address that maps to neither the key nor a protected register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| prot_wr_en | output | 1 | Qualified write enable to the protected registers |
| unlocked | output | 1 | Lock status, 1 = protected writes allowed |

## Verification
A tracker stuck in the wrong state shows up at the port within one write. It either opens after a byte sequence that should not open it, or it fails to open after the third correct byte. Either way, the status bit read at the key address is wrong in the cycle right after that write. The bench sweeps every byte value in each of the three key positions, and also drives the restart and interleaving cases, so any misrouted transition is caught. Wrong gating would let a locked write change a protected register; that change is visible on the next read of that register.

// File: rtl/prot_unlock_pkg.sv
package prot_unlock_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_B0 = 8'h59;
  localparam logic [KEY_W-1:0] KEY_B1 = 8'h16;
  localparam logic [KEY_W-1:0] KEY_B2 = 8'h88;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_OPEN = 2'd3
  } key_st_e;
endpackage

// File: rtl/prot_key_fsm.sv
module prot_key_fsm
  import prot_unlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_byte,
  output logic             open
);
  key_st_e st_q, st_d;

  // restart rule: a mismatch that equals the first byte begins a new sequence
  function automatic key_st_e restart(input logic [KEY_W-1:0] b);
    return (b == KEY_B0) ? ST_ONE : ST_IDLE;
  endfunction

  always_comb begin
    st_d = st_q;
    if (key_we) begin
      unique case (st_q)
        ST_IDLE: st_d = restart(key_byte);
        ST_ONE:  st_d = (key_byte == KEY_B1) ? ST_TWO  : restart(key_byte);
        ST_TWO:  st_d = (key_byte == KEY_B2) ? ST_OPEN : restart(key_byte);
        ST_OPEN: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign open = (st_q == ST_OPEN);
endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 3,
  parameter int PROT_BASE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_PROT*DATA_W-1:0] q_flat,
  output logic [DATA_W-1:0]          rd_data
);
  logic [NUM_PROT-1:0] sel;

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_reg
    assign sel[g] = (addr == ADDR_W'(PROT_BASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q_flat[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && sel[g]) q_flat[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PROT; i++)
      if (sel[i]) rd_data = rd_data | q_flat[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/prot_unlock_seq.sv
module prot_unlock_seq
  import prot_unlock_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 3,
  parameter int KEY_ADDR  = 0,
  parameter int PROT_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              prot_wr_en,
  output logic              unlocked
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(PROT_BASE);
  localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(PROT_BASE + NUM_PROT - 1);

  logic                       key_hit, prot_hit, open;
  logic [NUM_PROT*DATA_W-1:0] prot_q;
  logic [DATA_W-1:0]          bank_rd;

  assign key_hit  = (bus_addr == KEY_A);
  assign prot_hit = (bus_addr >= LO_A) && (bus_addr <= HI_A);

  prot_key_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (bus_we && key_hit),
    .key_byte (bus_wdata[KEY_W-1:0]),
    .open     (open)
  );

  assign prot_wr_en = bus_we && prot_hit && open;

  prot_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT), .PROT_BASE(PROT_BASE)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prot_wr_en),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .q_flat  (prot_q),
    .rd_data (bank_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (key_hit)       bus_rdata[0] = open;
    else if (prot_hit) bus_rdata    = bank_rd;
  end

  assign unlocked = open;
endmodule

// File: rtl/prot_unlock_chk.sv
module prot_unlock_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 3,
  parameter int KEY_ADDR  = 0,
  parameter int PROT_BASE = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       bus_we,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       prot_wr_en,
  input logic                       unlocked,
  input logic [NUM_PROT*DATA_W-1:0] prot_q
);
  logic key_wr, prot_wr;
  assign key_wr  = bus_we && (bus_addr == ADDR_W'(KEY_ADDR));
  assign prot_wr = bus_we && (bus_addr >= ADDR_W'(PROT_BASE)) &&
                   (bus_addr <= ADDR_W'(PROT_BASE + NUM_PROT - 1));

  a_r2_open_after_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && bus_wdata[7:0] == 8'h88));

  a_r7_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr) |=> !unlocked);

  a_r4_locked_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && prot_wr) |=> $stable(prot_q));

  a_r5_open_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && bus_we && bus_addr == ADDR_W'(PROT_BASE))
      |=> prot_q[DATA_W-1:0] == $past(bus_wdata));

  a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(KEY_ADDR)) |-> bus_rdata[DATA_W-1:1] == '0);
endmodule

bind prot_unlock_seq prot_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
  .KEY_ADDR(KEY_ADDR), .PROT_BASE(PROT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .prot_wr_en(prot_wr_en),
  .unlocked(unlocked), .prot_q(prot_q)
);

// File: tb/prot_unlock_seq_bench.sv
module prot_unlock_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        prot_wr_en, unlocked;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prot_unlock_seq u_prot_unlock_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .prot_wr_en(prot_wr_en),
    .unlocked(unlocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle write, inputs changed on falling edges
  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic we_seen);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    #1 we_seen = prot_wr_en;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'd0;
  endtask

  task automatic w(input logic [3:0] a, input logic [31:0] d);
    logic s;
    wr(a, d, s);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // reference tracker: 0 idle, 1 one byte, 2 two bytes, 3 open
  function automatic int model(input int st, input logic [7:0] b);
    int rs = (b == 8'h59) ? 1 : 0;
    case (st)
      0: return rs;
      1: return (b == 8'h16) ? 2 : rs;
      2: return (b == 8'h88) ? 3 : rs;
      default: return 0;
    endcase
  endfunction

  task automatic relock_if_open();
    logic [31:0] r;
    rd(4'd0, r);
    if (r[0]) w(4'd0, 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    logic s;
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, r); check("R1 status", r, 0);
    for (int a = 1; a <= 3; a++) begin rd(4'(a), r); check("R1 prot reg", r, 0); end
    // R4 locked write dropped
    wr(4'd1, 32'hDEADBEEF, s); check("R4 qualifier low", {31'b0, s}, 0);
    rd(4'd1, r); check("R4 locked write dropped", r, 0);
    // R2 exact sequence, status only after third byte
    w(4'd0, 32'h59); rd(4'd0, r); check("R2 not open after 1", r, 0);
    w(4'd0, 32'h16); rd(4'd0, r); check("R2 not open after 2", r, 0);
    w(4'd0, 32'h88); rd(4'd0, r); check("R2 open after 3", r, 1);
    check("R2 unlocked pin", {31'b0, unlocked}, 1);
    // R5 write while open
    wr(4'd2, 32'hA5A5_1234, s); check("R5 qualifier high", {31'b0, s}, 1);
    rd(4'd2, r); check("R5 write stored", r, 32'hA5A5_1234);
    // R9 unmapped
    rd(4'd9, r); check("R9 unmapped zero", r, 0);
    // R7 relock with arbitrary value
    w(4'd0, 32'hFFFF_FF59); rd(4'd0, r); check("R7 relocked", r, 0);
    wr(4'd2, 32'h1, s); rd(4'd2, r); check("R4 after relock", r, 32'hA5A5_1234);
    // R6 repeated first byte
    w(4'd0, 32'h59); w(4'd0, 32'h59); w(4'd0, 32'h16); w(4'd0, 32'h88);
    rd(4'd0, r); check("R6 59 59 16 88 opens", r, 1);
    relock_if_open();
    w(4'd0, 32'h59); w(4'd0, 32'h16); w(4'd0, 32'h59); w(4'd0, 32'h16); w(4'd0, 32'h88);
    rd(4'd0, r); check("R6 restart on 59 opens", r, 1);
    relock_if_open();
    w(4'd0, 32'h59); w(4'd0, 32'h16); w(4'd0, 32'h16); w(4'd0, 32'h88);
    rd(4'd0, r); check("R6 broken stays locked", r, 0);
    // R8 other addresses between key bytes
    w(4'd0, 32'h59); w(4'd3, 32'h77); w(4'd12, 32'h5); w(4'd0, 32'h16);
    rd(4'd3, r); check("R8 locked write in gap dropped", r, 0);
    w(4'd0, 32'h88); rd(4'd0, r); check("R8 sequence survives", r, 1);
    // R3 key readback upper bits zero while open
    rd(4'd0, r); check("R3 key readback", r, 32'h1);
    relock_if_open();
    // sweeps over every byte in each key position
    for (int pos = 0; pos < 3; pos++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] seq [3];
        seq[0] = 8'h59; seq[1] = 8'h16; seq[2] = 8'h88;
        seq[pos] = 8'(b);
        st = 0;
        for (int k = 0; k < 3; k++) begin
          w(4'd0, {24'hABCDEF, seq[k]});
          st = model(st, seq[k]);
        end
        rd(4'd0, r);
        check(pos == 2 ? "R2 sweep last" : "R6 sweep", r, (st == 3) ? 1 : 0);
        relock_if_open();
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule